// File: doc/BRIEF.md
# External Interrupt Conditioning Unit

This block sits between 32 external interrupt sources and an interrupt controller that accepts only active-high level requests. Each input line can be set up on its own to sense a rising edge, a falling edge, a high level or a low level. A detected trigger sets a request latch for that line. The latch stays set until software clears it. Each output line presents its latch gated by a per-line mask bit.

Masking only gates the output. A masked line keeps capturing triggers, so a request that arrives while the line is masked shows up on the output as soon as the mask bit drops. Software uses a small register port with 3-bit word addressing and single-cycle writes. Reads are combinational from the word address. Every input first passes through a two-flop synchronizer, so a request reaches the output three clock edges after the input changes.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset, the mask word (word 0, byte 0x00) reads all ones. The polarity word (word 5, byte 0x14) and the edge-select word (word 6, byte 0x18) read zero. Raw status reads zero and all outputs are low. The synchronizer and previous-value flops reset to the high (idle) level.
- R2: The mask, polarity and edge-select words can be written and read back. Words 1 and 7 (bytes 0x04, 0x1C) ignore writes and read zero. The clear word (word 4, byte 0x10) reads zero.
- R3: Edge-select bit 1 with polarity bit 1 latches a low-to-high input transition. The latch is visible on raw status (word 3, byte 0x0C) after the third rising clock edge following the input change and not after the second. It stays set after the input returns low.
- R4: Edge-select bit 1 with polarity bit 0 latches a high-to-low input transition, with the same latency and the same persistence as R3.
- R5: Edge-select bit 0 with polarity bit 1 is level-high mode. The request sets every cycle the synchronized input is high. A clear issued while the input is still high does not drop it. A clear issued once the input is low does drop it.
- R6: Edge-select bit 0 with polarity bit 0 is level-low mode. It behaves as R5 with the active level being low.
- R7: A mask bit of 1 holds its output low while the request latch keeps capturing triggers. Clearing the mask bit then drives the output high.
- R8: Writing the clear word clears every line whose data bit is 1. Bits written as 0 leave their latches unchanged.
- R9: When a trigger and a clear for the same line fall in the same cycle, the request stays set.
- R10: With all inputs at their inactive levels, writing all ones to the clear word and then all ones to the mask word leaves raw status zero and every output low.
- R11: Masked status (word 2, byte 0x08) equals raw status with masked lines removed, and the output vector equals masked status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_i | input | 32 | Asynchronous external interrupt lines |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for the word at reg_addr_i |
| irq_o | output | 32 | Active-high level requests to the interrupt controller |

## Verification
A latch that fails to set or fails to clear shows on raw status and on the output within one cycle of the edge that should have changed it. The bench therefore samples one cycle before and at the expected edge to catch wrong latency. A wrong mask or configuration bit shows as a mismatch between raw status, masked status and the output vector, visible immediately on read. A clear-versus-trigger priority error only shows when both events meet in the same cycle. The bench therefore places a clear write exactly on the capture edge of an edge trigger.

// File: rtl/extirq_pkg.sv
`timescale 1ns/1ps
package extirq_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic IDLE_LVL = 1'b1;

  typedef enum logic [ADDR_W-1:0] {
    W_MASK = 3'd0,
    W_RSV1 = 3'd1,
    W_MSTA = 3'd2,
    W_RAW  = 3'd3,
    W_CLR  = 3'd4,
    W_POL  = 3'd5,
    W_EDGE = 3'd6,
    W_RSV7 = 3'd7
  } word_e;
endpackage

// File: rtl/extirq_sync.sv
`timescale 1ns/1ps
module extirq_sync #(
  parameter int unsigned WIDTH = 32,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {WIDTH{RST_VAL}};
      stab_q <= {WIDTH{RST_VAL}};
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/extirq_detect.sv
`timescale 1ns/1ps
module extirq_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic pol_i,
  input  logic edge_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic pend_o,
  output logic irq_o
);
  import extirq_pkg::*;

  logic prev_q, lat_q, lat_d, trig;
  logic act_now, act_prev;

  // Active level after polarity; edge mode looks for inactive -> active.
  always_comb begin
    act_now  = pol_i ? lvl_i  : ~lvl_i;
    act_prev = pol_i ? prev_q : ~prev_q;
    trig     = edge_i ? (act_now & ~act_prev) : act_now;
    lat_d    = trig | (lat_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= IDLE_LVL;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      lat_q  <= lat_d;
    end
  end

  assign pend_o = lat_q;
  assign irq_o  = lat_q & ~mask_i;

  // R9
  trig_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> lat_q);
  // R8
  clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !trig) |=> !lat_q);
  // R3
  set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_q) |-> $past(trig));
endmodule

// File: rtl/extirq_regs.sv
`timescale 1ns/1ps
module extirq_regs #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_i,
  input  logic [extirq_pkg::ADDR_W-1:0] addr_i,
  input  logic [NUM_LINES-1:0]          wdata_i,
  input  logic [NUM_LINES-1:0]          raw_i,
  output logic [NUM_LINES-1:0]          rdata_o,
  output logic [NUM_LINES-1:0]          mask_o,
  output logic [NUM_LINES-1:0]          pol_o,
  output logic [NUM_LINES-1:0]          edge_o,
  output logic [NUM_LINES-1:0]          clr_o
);
  import extirq_pkg::*;

  logic [NUM_LINES-1:0] mask_q, mask_d, pol_q, pol_d, edge_q, edge_d;
  logic                 mask_en, pol_en, edge_en;

  always_comb begin
    mask_en = wr_i && (addr_i == W_MASK);
    pol_en  = wr_i && (addr_i == W_POL);
    edge_en = wr_i && (addr_i == W_EDGE);
    mask_d  = mask_en ? wdata_i : mask_q;
    pol_d   = pol_en  ? wdata_i : pol_q;
    edge_d  = edge_en ? wdata_i : edge_q;
    clr_o   = (wr_i && (addr_i == W_CLR)) ? wdata_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      pol_q  <= '0;
      edge_q <= '0;
    end else begin
      mask_q <= mask_d;
      pol_q  <= pol_d;
      edge_q <= edge_d;
    end
  end

  always_comb begin
    case (addr_i)
      W_MASK:  rdata_o = mask_q;
      W_MSTA:  rdata_o = raw_i & ~mask_q;
      W_RAW:   rdata_o = raw_i;
      W_POL:   rdata_o = pol_q;
      W_EDGE:  rdata_o = edge_q;
      default: rdata_o = '0;
    endcase
  end

  assign mask_o = mask_q;
  assign pol_o  = pol_q;
  assign edge_o = edge_q;

  // R2
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == W_MASK) |=> (mask_o == $past(wdata_i)));
  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i) |=> ($stable(pol_o) && $stable(edge_o) && $stable(mask_o)));
endmodule

// File: rtl/ext_irq_cond.sv
`timescale 1ns/1ps
module ext_irq_cond #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_LINES-1:0]          ext_irq_i,
  input  logic                          reg_wr_i,
  input  logic [extirq_pkg::ADDR_W-1:0] reg_addr_i,
  input  logic [NUM_LINES-1:0]          reg_wdata_i,
  output logic [NUM_LINES-1:0]          reg_rdata_o,
  output logic [NUM_LINES-1:0]          irq_o
);
  import extirq_pkg::*;

  logic [NUM_LINES-1:0] lvl, mask, pol, edg, clr, pend;

  extirq_sync #(.WIDTH(NUM_LINES), .RST_VAL(IDLE_LVL)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ext_irq_i), .sync_o(lvl)
  );

  extirq_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .raw_i(pend), .rdata_o(reg_rdata_o),
    .mask_o(mask), .pol_o(pol), .edge_o(edg), .clr_o(clr)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    extirq_detect u_det (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl[i]), .pol_i(pol[i]),
      .edge_i(edg[i]), .clr_i(clr[i]), .mask_i(mask[i]),
      .pend_o(pend[i]), .irq_o(irq_o[i])
    );
  end

  // R11
  msta_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == W_MSTA) |-> (reg_rdata_o == irq_o));
  // R7
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & mask) == '0));
endmodule

// File: tb/tb_ext_irq_cond.sv
`timescale 1ns/1ps
module tb_ext_irq_cond;
  localparam int N = 32;
  localparam logic [2:0] A_MASK = 3'd0, A_RSV1 = 3'd1, A_MSTA = 3'd2,
    A_RAW = 3'd3, A_CLR = 3'd4, A_POL = 3'd5, A_EDGE = 3'd6, A_RSV7 = 3'd7;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] ext;
  logic wr;
  logic [2:0] addr;
  logic [N-1:0] wdata, rdata, irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ext_irq_cond #(.NUM_LINES(N)) dut (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(ext), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [N-1:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic t_reset;
    logic [N-1:0] v;
    rd_reg(A_MASK, v); chk("R1 mask", v, '1);
    rd_reg(A_POL, v);  chk("R1 pol", v, '0);
    rd_reg(A_EDGE, v); chk("R1 edge", v, '0);
    rd_reg(A_RAW, v);  chk("R1 raw", v, '0);
    chk("R1 irq", irq, '0);
  endtask

  task automatic t_regmap;
    logic [N-1:0] v;
    wr_reg(A_EDGE, 32'hA5A5_0F0F); rd_reg(A_EDGE, v); chk("R2 edge rw", v, 32'hA5A5_0F0F);
    wr_reg(A_EDGE, '0);
    wr_reg(A_RSV1, '1); rd_reg(A_RSV1, v); chk("R2 word1", v, '0);
    wr_reg(A_RSV7, '1); rd_reg(A_RSV7, v); chk("R2 word7", v, '0);
    rd_reg(A_CLR, v); chk("R2 clr reads 0", v, '0);
    rd_reg(A_MASK, v); chk("R2 mask untouched", v, '1);
  endtask

  task automatic t_setup;
    logic [N-1:0] v;
    wr_reg(A_POL, 32'h5);
    wr_reg(A_EDGE, 32'h3);
    @(negedge clk); ext = 32'hFFFF_FFFA;
    repeat (4) @(posedge clk);
    wr_reg(A_CLR, '1);
    rd_reg(A_RAW, v); chk("R8 clear all", v, '0);
    wr_reg(A_MASK, ~32'hF);
  endtask

  task automatic t_edge(input int ln, input logic newv, input string req);
    logic [N-1:0] v;
    @(negedge clk); ext[ln] = newv;
    @(posedge clk); @(posedge clk); #1;
    rd_reg(A_RAW, v); chk({req, " not yet"}, v[ln], 1'b0);
    @(posedge clk); #1;
    rd_reg(A_RAW, v); chk({req, " latched"}, v[ln], 1'b1);
    chk({req, " irq"}, irq[ln], 1'b1);
    @(negedge clk); ext[ln] = ~newv;
    repeat (4) @(posedge clk); #1;
    rd_reg(A_RAW, v); chk({req, " persists"}, v[ln], 1'b1);
    wr_reg(A_CLR, 32'(1) << ln);
    rd_reg(A_RAW, v); chk("R8 clear bit", v[ln], 1'b0);
  endtask

  task automatic t_level(input int ln, input logic actv, input string req);
    logic [N-1:0] v;
    @(negedge clk); ext[ln] = actv;
    repeat (3) @(posedge clk); #1;
    rd_reg(A_RAW, v); chk({req, " set"}, v[ln], 1'b1);
    wr_reg(A_CLR, 32'(1) << ln);
    rd_reg(A_RAW, v); chk({req, " clear while active"}, v[ln], 1'b1);
    @(negedge clk); ext[ln] = ~actv;
    repeat (3) @(posedge clk);
    wr_reg(A_CLR, 32'(1) << ln);
    rd_reg(A_RAW, v); chk({req, " clear when idle"}, v[ln], 1'b0);
  endtask

  task automatic t_mask;
    logic [N-1:0] v;
    wr_reg(A_MASK, ~32'hE);
    @(negedge clk); ext[0] = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk("R7 masked irq low", irq[0], 1'b0);
    rd_reg(A_RAW, v);  chk("R7 latch while masked", v[0], 1'b1);
    rd_reg(A_MSTA, v); chk("R11 masked status", v, 32'h0);
    wr_reg(A_MASK, ~32'hF);
    chk("R7 unmask irq", irq[0], 1'b1);
    rd_reg(A_MSTA, v); chk("R11 msta equals irq", v, irq);
    wr_reg(A_CLR, '0);
    rd_reg(A_RAW, v); chk("R8 zero bits ignored", v[0], 1'b1);
  endtask

  task automatic t_collide;
    logic [N-1:0] v;
    @(negedge clk); ext[0] = 1'b0;
    repeat (4) @(posedge clk);
    wr_reg(A_CLR, 32'h1);
    rd_reg(A_RAW, v); chk("R9 pre-clear", v[0], 1'b0);
    @(negedge clk); ext[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr_reg(A_CLR, 32'h1);
    rd_reg(A_RAW, v); chk("R9 trigger beats clear", v[0], 1'b1);
  endtask

  task automatic t_init_seq;
    logic [N-1:0] v;
    @(negedge clk); ext[1] = 1'b1; ext[5] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); ext[5] = 1'b1;
    repeat (4) @(posedge clk); #1;
    rd_reg(A_RAW, v); chk("R10 latches present", v & 32'h21, 32'h21);
    wr_reg(A_CLR, '1);
    wr_reg(A_MASK, '1);
    repeat (2) @(posedge clk); #1;
    rd_reg(A_RAW, v); chk("R10 raw empty", v, '0);
    chk("R10 irq low", irq, '0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ext = '1; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    t_reset;
    t_regmap;
    t_setup;
    t_edge(0, 1'b1, "R3 rising");
    t_edge(1, 1'b0, "R4 falling");
    t_level(2, 1'b1, "R5 level high");
    t_level(3, 1'b0, "R6 level low");
    t_mask;
    t_collide;
    t_init_seq;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule